// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a double-data-rate SDRAM from power-up to the point where normal accesses may begin. It waits for an external flag that says the clock and supply stabilization delay has elapsed. It then drives a fixed series of commands on the memory command bus: a precharge of all banks, two auto-refresh cycles, a load of the extended mode register and a load of the main mode register. Finally it raises a done flag that the access scheduler waits on.

Every gap between two commands is timed by an internal down-counter whose reload values are parameters given in clock cycles. During those gaps the bus carries NOP. The mode register word is assembled from the CAS latency, burst length and burst ordering parameters. The extended mode register word is a parameter passed through unchanged. Illegal parameter combinations stop elaboration.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While `rst` is high on a clock edge, the block returns to its idle state. From the next cycle the bus shows NOP and `init_done` is low.
- R2: After reset, as long as `clk_stable` is sampled low, no command other than NOP is issued and `init_done` stays low.
- R3: Suppose `clk_stable` is first sampled high at edge k while the block is idle. Then the precharge command is on the bus in the cycle after edge k+1, with exactly one NOP cycle between.
- R4: The command code is {cs_n, ras_n, cas_n, we_n}: NOP = 0111, PRECHARGE = 0010, AUTO REFRESH = 0001, LOAD MODE = 0000. Each command lasts exactly one cycle, and NOP is driven in every other cycle.
- R5: The precharge command drives address bit 10 high (all banks) with every other address bit and the bank address zero.
- R6: The commands come in this order: precharge, refresh, refresh, LOAD MODE with bank address 1 carrying `EMR_VALUE`, LOAD MODE with bank address 0. The refreshes carry zero address and bank.
- R7: The mode register word puts the burst length code in bits [2:0] (001 = 2, 010 = 4, 011 = 8). Bit 3 is 1 for interleaved order and 0 for sequential. The CAS latency is a binary value in bits [6:4]. All higher bits are zero.
- R8: The first refresh comes exactly `T_RP_CYC` cycles after the precharge. The second refresh and the extended mode load each come exactly `T_RFC_CYC` cycles after the refresh before them. The mode load comes exactly `T_MRD_CYC` cycles after the extended mode load.
- R9: `init_done` rises exactly `T_MRD_CYC` cycles after the mode register load.
- R10: Once `init_done` is high, it stays high and only NOP is driven until the next reset, whatever `clk_stable` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_stable | input | 1 | High once the external stabilization delay has elapsed |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ADDR_W | Address / mode word |
| init_done | output | 1 | Sequence complete |

## Verification
The hardest condition to reach from the ports is a reset that lands inside a refresh wait window, followed by a restart. The restart must begin from idle with a fresh precharge and must not resume the old count. The stimulus reaches that point by counting cycles from the observed precharge. It pulses reset part way through the refresh spacing. It then holds the stabilization flag low, to show that the sequence really went back to idle, before raising the flag again. A second hard condition is a drop of the stabilization flag after completion. It is driven while the done flag is high, to show that the flag is latched.

// File: rtl/sdram_pwrup_pkg.sv
package sdram_pwrup_pkg;

   // {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_LMR = 4'b0000,
      CMD_REF = 4'b0001,
      CMD_PRE = 4'b0010,
      CMD_NOP = 4'b0111
   } sdr_cmd_e;

   typedef enum logic [3:0] {
      S_IDLE,
      S_NOP,
      S_PRE,
      S_WRP,
      S_AR1,
      S_WRF1,
      S_AR2,
      S_WRF2,
      S_EMR,
      S_WEM,
      S_MRS,
      S_WMR,
      S_READY
   } seq_st_e;

   function automatic logic [2:0] burst_code(input int unsigned bl);
      case (bl)
         2:       return 3'b001;
         4:       return 3'b010;
         8:       return 3'b011;
         default: return 3'b000;
      endcase
   endfunction

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/pwrup_wait_ctr.sv
module pwrup_wait_ctr #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/pwrup_mode_word.sv
module pwrup_mode_word #(
   parameter int unsigned ADDR_W           = 13,
   parameter int unsigned CAS_LAT          = 3,
   parameter int unsigned BURST_LEN        = 4,
   parameter bit          BURST_INTERLEAVE = 1'b0,
   parameter logic [ADDR_W-1:0] EMR_VALUE  = '0
) (
   output logic [ADDR_W-1:0] mr_word,
   output logic [ADDR_W-1:0] emr_word
);
   import sdram_pwrup_pkg::*;

   localparam int unsigned LOW_W = 7;
   localparam logic [2:0]  BL_CODE = burst_code(BURST_LEN);
   localparam logic [2:0]  CL_CODE = 3'(CAS_LAT);

   logic       order_bit;
   logic [LOW_W-1:0] low_field;

   generate
      if (BURST_INTERLEAVE) begin : g_intlv
         assign order_bit = 1'b1;
      end else begin : g_seq
         assign order_bit = 1'b0;
      end
   endgenerate

   assign low_field = {CL_CODE, order_bit, BL_CODE};

   generate
      if (ADDR_W > LOW_W) begin : g_wide
         assign mr_word = {{(ADDR_W-LOW_W){1'b0}}, low_field};
      end else begin : g_narrow
         assign mr_word = low_field[ADDR_W-1:0];
      end
   endgenerate

   assign emr_word = EMR_VALUE;

endmodule

// File: rtl/pwrup_cmd_decode.sv
module pwrup_cmd_decode #(
   parameter int unsigned ADDR_W = 13,
   parameter int unsigned BA_W   = 2
) (
   input  sdram_pwrup_pkg::seq_st_e st,
   input  logic [ADDR_W-1:0]        mr_word,
   input  logic [ADDR_W-1:0]        emr_word,
   output logic [3:0]               cmd,
   output logic [BA_W-1:0]          ba,
   output logic [ADDR_W-1:0]        addr
);
   import sdram_pwrup_pkg::*;

   localparam int unsigned AP_BIT = 10;

   always_comb begin
      cmd  = CMD_NOP;
      ba   = '0;
      addr = '0;
      case (st)
         S_PRE: begin
            cmd          = CMD_PRE;
            addr[AP_BIT] = 1'b1;
         end
         S_AR1, S_AR2: cmd = CMD_REF;
         S_EMR: begin
            cmd  = CMD_LMR;
            ba   = BA_W'(1);
            addr = emr_word;
         end
         S_MRS: begin
            cmd  = CMD_LMR;
            addr = mr_word;
         end
         default: cmd = CMD_NOP;
      endcase
   end

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq #(
   parameter int unsigned ADDR_W           = 13,
   parameter int unsigned BA_W             = 2,
   parameter int unsigned T_RP_CYC         = 3,
   parameter int unsigned T_RFC_CYC        = 10,
   parameter int unsigned T_MRD_CYC        = 2,
   parameter int unsigned CAS_LAT          = 3,
   parameter int unsigned BURST_LEN        = 4,
   parameter bit          BURST_INTERLEAVE = 1'b0,
   parameter logic [ADDR_W-1:0] EMR_VALUE  = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clk_stable,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [BA_W-1:0]   sd_ba,
   output logic [ADDR_W-1:0] sd_addr,
   output logic              init_done
);
   import sdram_pwrup_pkg::*;

   localparam int unsigned MAX_T = max3(T_RP_CYC, T_RFC_CYC, T_MRD_CYC);
   localparam int unsigned CNT_W = (MAX_T < 2) ? 1 : $clog2(MAX_T);
   localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP_CYC - 2);
   localparam logic [CNT_W-1:0] LD_RFC = CNT_W'(T_RFC_CYC - 2);
   localparam logic [CNT_W-1:0] LD_MRD = CNT_W'(T_MRD_CYC - 2);

   // elaboration-time legality checks
   generate
      if (T_RP_CYC < 2 || T_RFC_CYC < 2 || T_MRD_CYC < 2) begin : g_bad_timing
         $error("sdram_pwrup_seq: every spacing must be at least 2 cycles");
      end
      if (BURST_LEN != 2 && BURST_LEN != 4 && BURST_LEN != 8) begin : g_bad_bl
         $error("sdram_pwrup_seq: burst length must be 2, 4 or 8");
      end
      if (CAS_LAT < 2 || CAS_LAT > 7) begin : g_bad_cl
         $error("sdram_pwrup_seq: CAS latency out of range");
      end
      if (ADDR_W < 11 || BA_W < 1) begin : g_bad_w
         $error("sdram_pwrup_seq: address must reach bit 10, bank width >= 1");
      end
   endgenerate

   seq_st_e          st_q, st_d;
   logic             ld;
   logic [CNT_W-1:0] ld_val;
   logic             expired;
   logic [ADDR_W-1:0] mr_word, emr_word;
   logic [3:0]       cmd;

   always_ff @(posedge clk) begin
      if (rst) st_q <= S_IDLE;
      else     st_q <= st_d;
   end

   always_comb begin
      st_d = st_q;
      case (st_q)
         S_IDLE:  if (clk_stable) st_d = S_NOP;
         S_NOP:   st_d = S_PRE;
         S_PRE:   st_d = S_WRP;
         S_WRP:   if (expired) st_d = S_AR1;
         S_AR1:   st_d = S_WRF1;
         S_WRF1:  if (expired) st_d = S_AR2;
         S_AR2:   st_d = S_WRF2;
         S_WRF2:  if (expired) st_d = S_EMR;
         S_EMR:   st_d = S_WEM;
         S_WEM:   if (expired) st_d = S_MRS;
         S_MRS:   st_d = S_WMR;
         S_WMR:   if (expired) st_d = S_READY;
         S_READY: st_d = S_READY;
         default: st_d = S_IDLE;
      endcase
   end

   // reload the spacing counter in each command cycle
   always_comb begin
      ld     = 1'b0;
      ld_val = '0;
      case (st_q)
         S_PRE:        begin ld = 1'b1; ld_val = LD_RP;  end
         S_AR1, S_AR2: begin ld = 1'b1; ld_val = LD_RFC; end
         S_EMR, S_MRS: begin ld = 1'b1; ld_val = LD_MRD; end
         default:      begin ld = 1'b0; ld_val = '0;     end
      endcase
   end

   pwrup_wait_ctr #(.CNT_W(CNT_W)) u_wait (
      .clk      (clk),
      .rst      (rst),
      .load     (ld),
      .load_val (ld_val),
      .expired  (expired)
   );

   pwrup_mode_word #(
      .ADDR_W           (ADDR_W),
      .CAS_LAT          (CAS_LAT),
      .BURST_LEN        (BURST_LEN),
      .BURST_INTERLEAVE (BURST_INTERLEAVE),
      .EMR_VALUE        (EMR_VALUE)
   ) u_mode (
      .mr_word  (mr_word),
      .emr_word (emr_word)
   );

   pwrup_cmd_decode #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_dec (
      .st       (st_q),
      .mr_word  (mr_word),
      .emr_word (emr_word),
      .cmd      (cmd),
      .ba       (sd_ba),
      .addr     (sd_addr)
   );

   assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
   assign init_done = (st_q == S_READY);

endmodule

// File: rtl/sdram_pwrup_chk.sv
module sdram_pwrup_chk #(
   parameter int unsigned ADDR_W = 13
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     clk_stable,
   input logic                     sd_cs_n,
   input logic                     sd_ras_n,
   input logic                     sd_cas_n,
   input logic                     sd_we_n,
   input logic [ADDR_W-1:0]        sd_addr,
   input logic                     init_done,
   input sdram_pwrup_pkg::seq_st_e st
);
   import sdram_pwrup_pkg::*;

   logic [3:0] cmd;
   assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

   p_reset_quiet_r1: assert property (@(posedge clk)
      rst |=> (cmd == CMD_NOP && !init_done));

   p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (st == S_IDLE && !clk_stable) |=> (st == S_IDLE && cmd == CMD_NOP));

   p_nop_then_pre_r3: assert property (@(posedge clk) disable iff (rst)
      (st == S_NOP) |=> (cmd == CMD_PRE));

   p_single_cycle_cmd_r4: assert property (@(posedge clk) disable iff (rst)
      (cmd != CMD_NOP) |=> (cmd == CMD_NOP));

   p_prech_all_r5: assert property (@(posedge clk) disable iff (rst)
      (cmd == CMD_PRE) |-> sd_addr[10]);

   p_done_sticky_r10: assert property (@(posedge clk) disable iff (rst)
      init_done |=> init_done);

   p_done_quiet_r10: assert property (@(posedge clk) disable iff (rst)
      init_done |-> (cmd == CMD_NOP));

endmodule

bind sdram_pwrup_seq sdram_pwrup_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .clk_stable (clk_stable),
   .sd_cs_n    (sd_cs_n),
   .sd_ras_n   (sd_ras_n),
   .sd_cas_n   (sd_cas_n),
   .sd_we_n    (sd_we_n),
   .sd_addr    (sd_addr),
   .init_done  (init_done),
   .st         (st_q)
);

// File: tb/tb_sdram_pwrup_seq.sv
module tb_sdram_pwrup_seq;

   localparam int CLK_PERIOD = 10;
   localparam int AW    = 13;
   localparam int BW    = 2;
   localparam int TRP   = 3;
   localparam int TRFC  = 5;
   localparam int TMRD  = 2;
   localparam int CL    = 3;
   localparam int BL    = 4;
   localparam bit INTLV = 1'b1;
   localparam logic [AW-1:0] EMR = 13'h0002;

   // per R7: [2:0] burst code, bit 3 ordering, [6:4] CAS latency
   localparam int BL_EXP = (BL == 8) ? 3 : (BL == 4) ? 2 : 1;
   localparam logic [AW-1:0] MR_EXP = AW'((CL << 4) | (int'(INTLV) << 3) | BL_EXP);

   // {cmd[3:0], ba[1:0], addr[12:0], gap[7:0]}
   localparam logic [26:0] VEC [5] = '{
      {4'b0010, 2'd0, 13'h0400, 8'd2},
      {4'b0001, 2'd0, 13'h0000, 8'(TRP)},
      {4'b0001, 2'd0, 13'h0000, 8'(TRFC)},
      {4'b0000, 2'd1, EMR,      8'(TRFC)},
      {4'b0000, 2'd0, MR_EXP,   8'(TMRD)}
   };

   logic clk = 1'b0;
   logic rst;
   logic clk_stable;
   logic cs_n, ras_n, cas_n, we_n;
   logic [BW-1:0] ba;
   logic [AW-1:0] addr;
   logic init_done;
   logic [3:0] cmd;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;
   assign cmd = {cs_n, ras_n, cas_n, we_n};

   sdram_pwrup_seq #(
      .ADDR_W(AW), .BA_W(BW), .T_RP_CYC(TRP), .T_RFC_CYC(TRFC), .T_MRD_CYC(TMRD),
      .CAS_LAT(CL), .BURST_LEN(BL), .BURST_INTERLEAVE(INTLV), .EMR_VALUE(EMR)
   ) dut (
      .clk(clk), .rst(rst), .clk_stable(clk_stable),
      .sd_cs_n(cs_n), .sd_ras_n(ras_n), .sd_cas_n(cas_n), .sd_we_n(we_n),
      .sd_ba(ba), .sd_addr(addr), .init_done(init_done)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // count falling edges until a non-NOP command shows up
   task automatic wait_cmd(output int gap);
      gap = 0;
      do begin
         @(negedge clk);
         gap++;
      end while (cmd == 4'b0111 && gap < 200);
   endtask

   initial begin
      int g;
      bit quiet;
      rst = 1'b1;
      clk_stable = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(cmd == 4'b0111, "R1", "cmd in reset", cmd, 4'b0111);
      check(!init_done, "R1", "done in reset", init_done, 0);
      rst = 1'b0;

      // R2: stabilization flag low keeps the block quiet
      quiet = 1'b1;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (cmd != 4'b0111 || init_done) quiet = 1'b0;
      end
      check(quiet, "R2", "idle while unstable", quiet, 1);

      clk_stable = 1'b1;
      // table walk: R3 (first gap), R4/R5/R6/R7 (fields), R8 (spacing)
      for (int i = 0; i < 5; i++) begin
         wait_cmd(g);
         check(cmd == VEC[i][26:23], "R6", $sformatf("cmd code #%0d", i), cmd, VEC[i][26:23]);
         check(ba == VEC[i][22:21], "R6", $sformatf("bank #%0d", i), ba, VEC[i][22:21]);
         check(addr == VEC[i][20:8], (i == 0) ? "R5" : (i == 4) ? "R7" : "R6",
               $sformatf("addr #%0d", i), addr, VEC[i][20:8]);
         check(g == int'(VEC[i][7:0]), (i == 0) ? "R3" : "R8",
               $sformatf("spacing #%0d", i), g, VEC[i][7:0]);
         @(negedge clk);
         check(cmd == 4'b0111, "R4", $sformatf("one-cycle cmd #%0d", i), cmd, 4'b0111);
         g = 1;
         if (i == 4) begin
            while (!init_done && g < 200) begin
               @(negedge clk);
               g++;
            end
            check(g == TMRD, "R9", "done delay after mode load", g, TMRD);
         end else if (i < 4) begin
            // step back: the next spacing count includes this cycle
            wait_cmd(g);
            g = g + 1;
            check(g == int'(VEC[i+1][7:0]), "R8", $sformatf("gap to #%0d", i+1), g, VEC[i+1][7:0]);
            check(cmd == VEC[i+1][26:23], "R6", $sformatf("order #%0d", i+1), cmd, VEC[i+1][26:23]);
            check(ba == VEC[i+1][22:21], "R6", $sformatf("order bank #%0d", i+1), ba, VEC[i+1][22:21]);
            check(addr == VEC[i+1][20:8], (i == 3) ? "R7" : "R6",
                  $sformatf("order addr #%0d", i+1), addr, VEC[i+1][20:8]);
            i++;
            if (i == 4) begin
               @(negedge clk);
               g = 1;
               while (!init_done && g < 200) begin
                  @(negedge clk);
                  g++;
               end
               check(g == TMRD, "R9", "done delay after mode load", g, TMRD);
            end
         end
      end

      // R10: done latched, bus quiet, stabilization flag ignored
      quiet = 1'b1;
      for (int i = 0; i < 30; i++) begin
         if (i == 10) clk_stable = 1'b0;
         @(negedge clk);
         if (!init_done || cmd != 4'b0111) quiet = 1'b0;
      end
      check(quiet, "R10", "done sticky and quiet", quiet, 1);

      // reset from ready, then restart with the flag already high
      clk_stable = 1'b1;
      rst = 1'b1;
      @(negedge clk);
      check(!init_done, "R1", "done cleared by reset", init_done, 0);
      rst = 1'b0;
      wait_cmd(g);
      check(g == 2 && cmd == 4'b0010, "R3", "restart to precharge", g, 2);

      // reset inside the first refresh wait window
      wait_cmd(g);
      @(negedge clk);
      @(negedge clk);
      rst = 1'b1;
      clk_stable = 1'b0;
      @(negedge clk);
      check(cmd == 4'b0111 && !init_done, "R1", "reset mid refresh", cmd, 4'b0111);
      rst = 1'b0;
      quiet = 1'b1;
      for (int i = 0; i < 15; i++) begin
         @(negedge clk);
         if (cmd != 4'b0111) quiet = 1'b0;
      end
      check(quiet, "R2", "no resume after mid reset", quiet, 1);
      clk_stable = 1'b1;
      wait_cmd(g);
      check(g == 2 && cmd == 4'b0010, "R3", "fresh precharge after mid reset", g, 2);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

endmodule